// File: doc/BRIEF.md
# Two-Bus Coherence Snoop Filter

This controller sits between two processor buses and one memory port. Each processor keeps a private cache, and the buses do not observe each other. Accesses whose line address falls inside a programmable shared window are looked up in a direct-mapped table. For every tracked line, the table records what each processor's cache holds: Modified, Shared or Invalid. The controller uses that record to decide whether the other processor must be snooped. When the record shows the other cache has no copy, the request goes straight to memory and the other bus sees no snoop traffic.

When the other cache holds a line dirty, the controller asks that cache to flush it. The flushed line is caught in a one-line snoop-hit buffer and written to memory, and the same data is returned to the requester. An ownership write against a Shared copy produces an invalidate on the other bus. Every in-window read is answered with the shared indication raised. This keeps a cache from installing the line as Exclusive and then upgrading it silently, which the table could not see. A table conflict first invalidates both holders of the old line, flushing it to memory if it was dirty. The two buses are served round-robin, and the table is written in the same cycle as the granted transaction.

Top module: `coh_filter_ctrl`

## Requirements
- R1: After reset, no acknowledge, snoop, memory read or memory write strobe is active. All table entries are empty, so the first access to any in-window line causes no snoop.
- R2: An address is inside the window when (addr - cfgBase) < cfgSpan in unsigned ADDR_W arithmetic. A request outside the window goes to memory with no snoop, no table change and the shared indication low.
- R3: Operation codes: if op bit 1 is set the request is a write-back. Otherwise, if op bit 0 is set it is an ownership write, and if neither bit is set it is a read. A request that needs no flush is acknowledged with a one-cycle busAck pulse in the cycle after it is granted, with memory data on busRdata for a read or an ownership write.
- R4: Every in-window read is acknowledged with busShared high for the requester. Ownership writes and write-backs return it low.
- R5: An in-window read or ownership write causes no snoop on the other bus when the table records the other cache as Invalid.
- R6: An ownership write while the other cache is recorded Shared pulses snpVld for the other bus with snpInv high and snpFlush low, at the line's address. Afterwards the writer is recorded Modified and the other cache Invalid.
- R7: When the other cache is recorded Modified, a read or ownership write pulses snpVld and snpFlush for that bus, with snpInv high only for an ownership write. The flushed line is written to memory. The same data is returned to the requester with busAck three cycles after the grant.
- R8: After a flush caused by a read, both caches are recorded Shared. A later ownership write by the previous owner therefore invalidates, and does not flush, the reader.
- R9: A write-back stores the bus write data to memory with no snoop and records the writer Invalid.
- R10: An in-window access that maps to a table slot holding a different line with any non-Invalid holder first snoops that old line on every holding bus with snpInv high and snpFlush high for a Modified holder. A dirty old line is written to memory. The request is then served, acknowledged four cycles after it was first granted.
- R11: When both buses request in the same cycle, the bus that was not acknowledged most recently is served first. Bus 0 wins the first such tie after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | First line address of the shared window |
| cfgSpan | input | ADDR_W | Number of lines in the shared window |
| busReq | input | 2 | Request, held until acknowledged, one bit per bus |
| busOp | input | 2x2 | Operation code per bus |
| busAddr | input | 2xADDR_W | Line address per bus |
| busWdata | input | 2xDATA_W | Write-back data per bus |
| busAck | output | 2 | One-cycle acknowledge per bus |
| busShared | output | 2 | Shared indication, valid with busAck |
| busRdata | output | DATA_W | Response line, valid with busAck |
| snpVld | output | 2 | Snoop strobe per bus |
| snpFlush | output | 2 | Snoop asks the cache to supply its dirty line |
| snpInv | output | 1 | Snoop invalidates the line in the targeted caches |
| snpAddr | output | ADDR_W | Line address of the snoop |
| snpData | input | 2xDATA_W | Line supplied by each cache while it is flushed |
| memRd | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory line address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, combinational |

## Verification
The hardest case to reach is a dirty table conflict. One cache must own a line in Modified, and then the other processor must touch a different in-window line that falls in the same slot, 64 lines away. The stimulus first steps each of eight lines through a fixed read, write, cross-read, cross-write and write-back sequence, so every table transition occurs for both bus orders. It then makes one cache own a swept line and sends an aliasing read from the other bus. The eviction flush has to show up at the old address, with memory updated, before the new request is acknowledged.

// File: rtl/coh_filter_pkg.sv
package coh_filter_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } lineSt_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SNOOP = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  typedef struct packed {
    logic respMem;
    logic respBuf;
    logic bufCap;
    logic bufSrc;
    logic memWrBuf;
    logic gBus;
  } dpStrobe_t;

endpackage

// File: rtl/coh_filter_dp.sv
module coh_filter_dp
  import coh_filter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic [1:0][DATA_W-1:0] busWdata,
  input  logic [1:0][DATA_W-1:0] snpData,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [DATA_W-1:0]      memWdata,
  output logic [DATA_W-1:0]      busRdata
);

  logic [DATA_W-1:0] hitBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitBuf   <= '0;
      busRdata <= '0;
    end else begin
      if (stb.bufCap) hitBuf <= snpData[stb.bufSrc];
      if (stb.respBuf) busRdata <= hitBuf;
      else if (stb.respMem) busRdata <= memRdata;
    end
  end

  assign memWdata = stb.memWrBuf ? hitBuf : busWdata[stb.gBus];

endmodule

// File: rtl/coh_filter_ctl.sv
module coh_filter_ctl
  import coh_filter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cfgBase,
  input  logic [ADDR_W-1:0]      cfgSpan,
  input  logic [1:0]             busReq,
  input  logic [1:0][1:0]        busOp,
  input  logic [1:0][ADDR_W-1:0] busAddr,
  output logic [1:0]             busAck,
  output logic [1:0]             busShared,
  output logic [1:0]             snpVld,
  output logic [1:0]             snpFlush,
  output logic                   snpInv,
  output logic [ADDR_W-1:0]      snpAddr,
  output logic                   memRd,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output dpStrobe_t              stb
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    lineSt_t          st0;
    lineSt_t          st1;
  } ent_t;

  ent_t   tbl [ENTRIES];
  phase_t phase;
  logic   rrLast, pendAck, pendBus, pendRd, dirty;

  logic [1:0]        elig;
  logic              gBus, anyReq, isWb, isOwn, isRd, inWin, tagHit, liveOld;
  logic [ADDR_W-1:0] gAddr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  ent_t              cur, newEnt;
  lineSt_t           stSelf, stOth, newSelf, newOth;
  logic              doEvict, doFlush, doSimple, doInvOnly;

  always_comb begin
    elig    = busReq & ~busAck;
    gBus    = (elig == 2'b11) ? ~rrLast : elig[1];
    anyReq  = (|elig) && (phase == PH_IDLE);
    gAddr   = busAddr[gBus];
    isWb    = busOp[gBus][1];
    isOwn   = ~busOp[gBus][1] & busOp[gBus][0];
    isRd    = ~busOp[gBus][1] & ~busOp[gBus][0];
    inWin   = (gAddr - cfgBase) < cfgSpan;
    idx     = gAddr[IDX_W-1:0];
    tag     = gAddr[ADDR_W-1:IDX_W];
    cur     = tbl[idx];
    tagHit  = cur.vld && (cur.tag == tag);
    liveOld = cur.vld && !tagHit && (cur.st0 != LN_I || cur.st1 != LN_I);
    stSelf  = !tagHit ? LN_I : (gBus ? cur.st1 : cur.st0);
    stOth   = !tagHit ? LN_I : (gBus ? cur.st0 : cur.st1);

    doEvict   = anyReq && inWin && liveOld;
    doFlush   = anyReq && !doEvict && inWin && !isWb && (stOth == LN_M);
    doSimple  = anyReq && !doEvict && !doFlush;
    doInvOnly = doSimple && inWin && isOwn && (stOth == LN_S);

    if (isWb) begin
      newSelf = LN_I;
      newOth  = stOth;
    end else if (isOwn) begin
      newSelf = LN_M;
      newOth  = LN_I;
    end else begin
      newSelf = (stSelf == LN_M) ? LN_M : LN_S;
      newOth  = (stOth == LN_M) ? LN_S : stOth;
    end
    newEnt = '{vld: 1'b1, tag: tag,
               st0: gBus ? newOth : newSelf,
               st1: gBus ? newSelf : newOth};

    memRd   = doSimple && !isWb;
    memWe   = (doSimple && isWb) || (phase == PH_DRAIN && dirty);
    memAddr = (phase == PH_DRAIN) ? snpAddr : gAddr;

    stb.respMem  = doSimple;
    stb.respBuf  = (phase == PH_DRAIN) && pendAck;
    stb.bufCap   = (phase == PH_SNOOP);
    stb.bufSrc   = snpFlush[1];
    stb.memWrBuf = (phase == PH_DRAIN);
    stb.gBus     = gBus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      rrLast    <= 1'b1;
      pendAck   <= 1'b0;
      pendBus   <= 1'b0;
      pendRd    <= 1'b0;
      dirty     <= 1'b0;
      busAck    <= '0;
      busShared <= '0;
      snpVld    <= '0;
      snpFlush  <= '0;
      snpInv    <= 1'b0;
      snpAddr   <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i].vld <= 1'b0;
    end else begin
      busAck    <= '0;
      busShared <= '0;
      snpVld    <= '0;
      snpFlush  <= '0;
      snpInv    <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (doEvict) begin
            snpVld   <= {cur.st1 != LN_I, cur.st0 != LN_I};
            snpFlush <= {cur.st1 == LN_M, cur.st0 == LN_M};
            snpInv   <= 1'b1;
            snpAddr  <= {cur.tag, idx};
            dirty    <= (cur.st0 == LN_M) || (cur.st1 == LN_M);
            pendAck  <= 1'b0;
            tbl[idx].vld <= 1'b0;
            phase    <= PH_SNOOP;
          end else if (doFlush) begin
            snpVld[~gBus]   <= 1'b1;
            snpFlush[~gBus] <= 1'b1;
            snpInv   <= isOwn;
            snpAddr  <= gAddr;
            dirty    <= 1'b1;
            pendAck  <= 1'b1;
            pendBus  <= gBus;
            pendRd   <= isRd;
            tbl[idx] <= newEnt;
            phase    <= PH_SNOOP;
          end else if (doSimple) begin
            busAck[gBus]    <= 1'b1;
            busShared[gBus] <= inWin && isRd;
            rrLast          <= gBus;
            if (inWin) tbl[idx] <= newEnt;
            if (doInvOnly) begin
              snpVld[~gBus] <= 1'b1;
              snpInv        <= 1'b1;
              snpAddr       <= gAddr;
            end
          end
        end
        PH_SNOOP: phase <= PH_DRAIN;
        default: begin
          if (pendAck) begin
            busAck[pendBus]    <= 1'b1;
            busShared[pendBus] <= pendRd;
            rrLast             <= pendBus;
          end
          phase <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/coh_filter_ctrl.sv
module coh_filter_ctrl
  import coh_filter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cfgBase,
  input  logic [ADDR_W-1:0]      cfgSpan,
  input  logic [1:0]             busReq,
  input  logic [1:0][1:0]        busOp,
  input  logic [1:0][ADDR_W-1:0] busAddr,
  input  logic [1:0][DATA_W-1:0] busWdata,
  output logic [1:0]             busAck,
  output logic [1:0]             busShared,
  output logic [DATA_W-1:0]      busRdata,
  output logic [1:0]             snpVld,
  output logic [1:0]             snpFlush,
  output logic                   snpInv,
  output logic [ADDR_W-1:0]      snpAddr,
  input  logic [1:0][DATA_W-1:0] snpData,
  output logic                   memRd,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata
);

  dpStrobe_t stb;

  coh_filter_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSpan(cfgSpan),
    .busReq(busReq), .busOp(busOp), .busAddr(busAddr),
    .busAck(busAck), .busShared(busShared),
    .snpVld(snpVld), .snpFlush(snpFlush), .snpInv(snpInv), .snpAddr(snpAddr),
    .memRd(memRd), .memWe(memWe), .memAddr(memAddr), .stb(stb)
  );

  coh_filter_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .snpData(snpData), .memRdata(memRdata), .memWdata(memWdata),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/coh_filter_chk.sv
module coh_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAck,
  input logic [1:0] busShared,
  input logic [1:0] snpVld,
  input logic [1:0] snpFlush,
  input logic       memRd,
  input logic       memWe
);

  // R3
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busAck));

  // R3
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWe));

  // R4
  shared_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busShared & ~busAck) == 2'b00);

  // R7
  flush_targets_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpFlush & ~snpVld) == 2'b00);

  // R7
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(snpFlush));

  // R7
  flush_drains_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|snpFlush) |=> (memWe && busAck == 2'b00));

endmodule

bind coh_filter_ctrl coh_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .busAck(busAck), .busShared(busShared),
  .snpVld(snpVld), .snpFlush(snpFlush), .memRd(memRd), .memWe(memWe)
);

// File: tb/sim_coh_filter_ctrl.sv
module sim_coh_filter_ctrl;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       cfgBase = 16'h0100;
  logic [15:0]       cfgSpan = 16'h0100;
  logic [1:0]        busReq = '0;
  logic [1:0][1:0]   busOp = '0;
  logic [1:0][15:0]  busAddr = '0;
  logic [1:0][31:0]  busWdata = '0;
  logic [1:0]        busAck, busShared, snpVld, snpFlush;
  logic [31:0]       busRdata;
  logic              snpInv, memRd, memWe;
  logic [15:0]       snpAddr, memAddr;
  logic [1:0][31:0]  cacheVal = '0;
  logic [31:0]       memWdata, memRdata;
  logic [31:0]       mem [1024];

  int checks = 0;
  int errors = 0;

  logic [1:0]  obsSnp, obsFlush, evSnp, evFlush;
  logic        obsInv, gotShared;
  logic [15:0] evAddr;
  logic [31:0] gotData;
  int          lat;
  int          lastAck = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_filter_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSpan(cfgSpan),
    .busReq(busReq), .busOp(busOp), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busShared(busShared), .busRdata(busRdata),
    .snpVld(snpVld), .snpFlush(snpFlush), .snpInv(snpInv), .snpAddr(snpAddr),
    .snpData(cacheVal), .memRd(memRd), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic issue(input int b, input logic [1:0] op, input logic [15:0] a,
                       input logic [31:0] wd);
    bit done = 0;
    @(negedge clk);
    busReq[b] = 1'b1; busOp[b] = op; busAddr[b] = a; busWdata[b] = wd;
    obsSnp = '0; obsFlush = '0; obsInv = 1'b0; evSnp = '0; evFlush = '0;
    evAddr = '0; lat = 0;
    for (int n = 0; n < 20 && !done; n++) begin
      @(negedge clk);
      lat++;
      if (snpVld != 2'b00) begin
        if (snpAddr == a) begin
          obsSnp |= snpVld; obsFlush |= snpFlush; obsInv |= snpInv;
        end else begin
          evSnp |= snpVld; evFlush |= snpFlush; evAddr = snpAddr;
        end
      end
      if (busAck[b]) begin
        gotData = busRdata; gotShared = busShared[b]; done = 1; lastAck = b;
      end
    end
    busReq[b] = 1'b0;
    chk("R3 request acknowledged", 32'(done), 32'd1);
  endtask

  task automatic both(input int expFirst);
    int first = -1;
    @(negedge clk);
    busOp = '0; busAddr[0] = 16'h0300; busAddr[1] = 16'h0301; busReq = 2'b11;
    for (int n = 0; n < 10 && busReq != 2'b00; n++) begin
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
        if (busAck[b] && busReq[b]) begin
          if (first < 0) first = b;
          busReq[b] = 1'b0;
          lastAck = b;
        end
      end
    end
    busReq = '0;
    chk("R11 round-robin first grant", 32'(first), 32'(expFirst));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] expd;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 + i * 5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 busAck idle", 32'(busAck), 0);
    chk("R1 snpVld idle", 32'(snpVld), 0);
    chk("R1 memRd idle", 32'(memRd), 0);
    chk("R1 memWe idle", 32'(memWe), 0);

    // R11: first tie after reset goes to bus 0
    both(0);

    // R2: window edges, shared flag and data
    begin
      logic [15:0] edges [4] = '{16'h00FF, 16'h0100, 16'h01FF, 16'h0200};
      for (int e = 0; e < 4; e++) begin
        expd = mem[edges[e][9:0]];
        issue(0, 2'b00, edges[e], 0);
        chk("R2 window shared flag", 32'(gotShared), (e == 1 || e == 2) ? 1 : 0);
        chk("R2 no snoop", 32'(obsSnp), 0);
        chk("R2 R3 read data", gotData, expd);
        chk("R3 latency", 32'(lat), 1);
      end
      // R2: out-of-window ownership write to a line already tracked leaves it alone
      issue(1, 2'b01, 16'h0200, 0);
      chk("R2 out-of-window write no snoop", 32'(obsSnp), 0);
      chk("R4 write shared low", 32'(gotShared), 0);
    end

    // Sweep: eight lines, both bus orders
    for (int k = 0; k < 8; k++) begin
      int ba = k % 2;
      int bb = 1 - ba;
      logic [15:0] a = 16'h0100 + 16'(k * 5);
      logic [31:0] wd = 32'h5EED_0000 + k;
      cacheVal[0] = 32'hC000_0000 + k * 16;
      cacheVal[1] = 32'hD000_0000 + k * 16 + 1;
      if (k == 0) begin
        // line 0x100 was read by bus 0 during the window test
        issue(0, 2'b11, a, mem[a[9:0]]);
      end
      expd = mem[a[9:0]];
      issue(ba, 2'b00, a, 0);
      chk("R5 first read no snoop", 32'(obsSnp), 0);
      chk("R4 read shared", 32'(gotShared), 1);
      chk("R3 read data", gotData, expd);
      issue(ba, 2'b01, a, 0);
      chk("R5 own write other invalid", 32'(obsSnp), 0);
      chk("R4 own write shared low", 32'(gotShared), 0);
      issue(bb, 2'b00, a, 0);
      chk("R7 read snoops owner", 32'(obsSnp), 32'(1 << ba));
      chk("R7 read flush", 32'(obsFlush), 32'(1 << ba));
      chk("R7 read no inv", 32'(obsInv), 0);
      chk("R7 flushed data", gotData, cacheVal[ba]);
      chk("R7 latency", 32'(lat), 3);
      chk("R4 flush read shared", 32'(gotShared), 1);
      chk("R7 memory updated", mem[a[9:0]], cacheVal[ba]);
      issue(ba, 2'b01, a, 0);
      chk("R6 R8 invalidate reader", 32'(obsSnp), 32'(1 << bb));
      chk("R6 R8 no flush", 32'(obsFlush), 0);
      chk("R6 inv flag", 32'(obsInv), 1);
      chk("R6 latency", 32'(lat), 1);
      issue(bb, 2'b01, a, 0);
      chk("R7 write flush+inv target", 32'(obsFlush), 32'(1 << ba));
      chk("R7 write inv", 32'(obsInv), 1);
      chk("R7 write data", gotData, cacheVal[ba]);
      issue(bb, 2'b10, a, wd);
      chk("R9 write-back no snoop", 32'(obsSnp), 0);
      chk("R9 memory stored", mem[a[9:0]], wd);
      issue(ba, 2'b00, a, 0);
      chk("R9 R5 read after write-back no snoop", 32'(obsSnp), 0);
      chk("R9 data from memory", gotData, wd);
    end

    // R10: clean eviction (0x100 held Shared by bus 0)
    expd = mem[10'h140];
    issue(1, 2'b00, 16'h0140, 0);
    chk("R10 clean evict targets", 32'(evSnp), 32'b01);
    chk("R10 clean evict no flush", 32'(evFlush), 0);
    chk("R10 evict address", 32'(evAddr), 32'h0100);
    chk("R10 new line no snoop", 32'(obsSnp), 0);
    chk("R10 latency", 32'(lat), 4);
    chk("R10 data", gotData, expd);

    // R10: dirty eviction (0x105 made Modified by bus 1)
    cacheVal[1] = 32'hBEEF_0105;
    issue(1, 2'b01, 16'h0105, 0);
    chk("R5 upgrade other invalid", 32'(obsSnp), 0);
    issue(0, 2'b00, 16'h0145, 0);
    chk("R10 dirty evict targets", 32'(evSnp), 32'b10);
    chk("R10 dirty evict flush", 32'(evFlush), 32'b10);
    chk("R10 dirty evict address", 32'(evAddr), 32'h0105);
    chk("R10 dirty line in memory", mem[10'h105], 32'hBEEF_0105);
    chk("R4 shared after evict", 32'(gotShared), 1);

    // R11: round robin after single requests
    issue(0, 2'b00, 16'h0300, 0);
    both(1);
    issue(1, 2'b00, 16'h0300, 0);
    both(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule